// File: doc/BRIEF.md
# Next-Program-Counter Unit

This unit owns the program counter of a 32-bit processor whose instructions are all one word long. From the current PC, the instruction word, the four condition flags (negative, zero, carry, overflow) and a precomputed register-plus-operand sum, it works out which address executes next. It also reports whether a return address must be written to the register file, and to which register.

Three kinds of instruction change control flow. A conditional branch carries a 22-bit signed word displacement. A call carries a 30-bit word displacement and always links into register 15. A register-indirect jump-and-link goes to the supplied sum. Both displacements are measured from the branching instruction itself. The value linked is the address of the call or jump instruction, not the one after it.

Every other instruction advances the PC by one word (4 bytes). The PC register is inside the block and loads the computed address on each clock edge where the advance enable is high.

Top module: `next_pc_unit`

## Requirements
- R1: After reset the PC reads 2048 (0x0000_0800), and while the advance enable is low the PC keeps its value on every clock edge.
- R2: On a clock edge with the advance enable high, the PC takes the value that `next_pc` showed before that edge.
- R3: When bits 31:30 of the instruction are 01 (call), `next_pc` is PC + (bits 29:0 × 4), modulo 2^32. The displacement is signed, so large values move the PC backward.
- R4: A call raises `link_we`, sets `link_idx` to 15 and sets `link_val` to the current PC.
- R5: When bits 31:30 are 00 and bits 24:22 are 010 (branch), the branch is taken according to the condition in bits 28:25. The codes are 0001 (zero flag set), 0110 (negative flag set), 0101 (carry flag set), 0111 (overflow flag set) and 1000 (always). A taken branch gives `next_pc` = PC + sign-extended bits 21:0 × 4, modulo 2^32.
- R6: A branch that is not taken gives `next_pc` = PC + 4. Condition codes other than the five listed are never taken, whatever the flags.
- R7: When bits 31:30 are 10 and bits 24:19 are 111000 (jump-and-link), `next_pc` equals `jmp_sum`. `link_idx` is bits 29:25, `link_val` is the current PC, and `link_we` is high only when bits 29:25 are nonzero.
- R8: Every other instruction gives `next_pc` = PC + 4 with `link_we` low, and branches give `link_we` low as well. This covers the set-high form (bits 31:30 = 00, bits 24:22 = 100), the remaining op 00 forms, op 10 with any other bits 24:19, and all of op 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_en | input | 1 | Load the PC with `next_pc` on this edge |
| instr | input | 32 | Instruction word at the current PC |
| flag_n | input | 1 | Negative condition flag |
| flag_z | input | 1 | Zero condition flag |
| flag_c | input | 1 | Carry condition flag |
| flag_v | input | 1 | Overflow condition flag |
| jmp_sum | input | 32 | Register plus operand sum used as the jump-and-link target |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address of the next instruction |
| link_we | output | 1 | Write the link value into the register file |
| link_idx | output | 5 | Register that receives the link value |
| link_val | output | 32 | Link value: the address of the current instruction |

## Verification
The bench sweeps every condition code against every flag combination. A decoder that reads the wrong bit or tests the wrong flag would then take branches it should skip, and a design that defaulted unlisted codes to "always" would jump on them. Displacements at both extremes of their signed ranges, applied with the PC near the top of the address space, expose any missing sign extension, missing ×4 scaling, or targets measured from PC+4. A jump-and-link sweep over all 32 destinations catches a link written for register 0. The link value is compared against the current PC, so a design that links the following address fails.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int XLEN     = 32;
  localparam int IDX_W    = 5;
  localparam int D22_W    = 22;
  localparam int D30_W    = 30;
  localparam int COND_W   = 4;

  localparam logic [1:0] OP_BRSET = 2'b00;
  localparam logic [1:0] OP_CALL  = 2'b01;
  localparam logic [1:0] OP_ALU   = 2'b10;

  localparam logic [2:0] SUB_BRANCH = 3'b010;
  localparam logic [2:0] SUB_SETHI  = 3'b100;
  localparam logic [5:0] ALU_JMPL   = 6'b111000;

  localparam logic [COND_W-1:0] CND_EQ  = 4'b0001;
  localparam logic [COND_W-1:0] CND_CS  = 4'b0101;
  localparam logic [COND_W-1:0] CND_NEG = 4'b0110;
  localparam logic [COND_W-1:0] CND_VS  = 4'b0111;
  localparam logic [COND_W-1:0] CND_ALW = 4'b1000;

  typedef enum logic [2:0] {
    FK_SEQ,
    FK_BRANCH,
    FK_CALL,
    FK_JMPL,
    FK_SETHI
  } flow_kind_e;

  // Sign-extended branch displacement in bytes.
  function automatic logic [XLEN-1:0] br_offset(input logic [D22_W-1:0] d);
    return {{(XLEN-D22_W-2){d[D22_W-1]}}, d, 2'b00};
  endfunction

  // Call displacement in bytes; the shift fills the full word.
  function automatic logic [XLEN-1:0] call_offset(input logic [D30_W-1:0] d);
    return {d, 2'b00};
  endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [XLEN-1:0]   instr,
  output flow_kind_e        kind,
  output logic [COND_W-1:0] cond,
  output logic [IDX_W-1:0]  rd,
  output logic [D22_W-1:0]  d22,
  output logic [D30_W-1:0]  d30
);

  logic [1:0] op;
  logic [2:0] sub2;
  logic [5:0] sub3;

  assign op   = instr[31:30];
  assign sub2 = instr[24:22];
  assign sub3 = instr[24:19];
  assign cond = instr[28:25];
  assign rd   = instr[29:25];
  assign d22  = instr[D22_W-1:0];
  assign d30  = instr[D30_W-1:0];

  always_comb begin
    kind = FK_SEQ;
    unique case (op)
      OP_CALL:  kind = FK_CALL;
      OP_BRSET: begin
        if (sub2 == SUB_BRANCH)     kind = FK_BRANCH;
        else if (sub2 == SUB_SETHI) kind = FK_SETHI;
      end
      OP_ALU:   if (sub3 == ALU_JMPL) kind = FK_JMPL;
      default:  kind = FK_SEQ;
    endcase
  end

endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic              f_n,
  input  logic              f_z,
  input  logic              f_c,
  input  logic              f_v,
  output logic              taken
);

  always_comb begin
    unique case (cond)
      CND_EQ:  taken = f_z;
      CND_NEG: taken = f_n;
      CND_CS:  taken = f_c;
      CND_VS:  taken = f_v;
      CND_ALW: taken = 1'b1;
      default: taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  flow_kind_e       kind,
  input  logic             br_taken,
  input  logic [XLEN-1:0]  pc,
  input  logic [D22_W-1:0] d22,
  input  logic [D30_W-1:0] d30,
  input  logic [XLEN-1:0]  jmp_sum,
  output logic [XLEN-1:0]  next_pc
);

  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] rel_target;

  // One shared adder: the offset mux picks the step or a displacement.
  always_comb begin
    offset = STEP;
    if (kind == FK_CALL)                 offset = call_offset(d30);
    else if (kind == FK_BRANCH && br_taken) offset = br_offset(d22);
  end

  assign rel_target = pc + offset;
  assign next_pc    = (kind == FK_JMPL) ? jmp_sum : rel_target;

endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'd2048,
  parameter int          LINK_REG = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv_en,
  input  logic [31:0] instr,
  input  logic        flag_n,
  input  logic        flag_z,
  input  logic        flag_c,
  input  logic        flag_v,
  input  logic [31:0] jmp_sum,
  output logic [31:0] pc,
  output logic [31:0] next_pc,
  output logic        link_we,
  output logic [4:0]  link_idx,
  output logic [31:0] link_val
);

  localparam logic [IDX_W-1:0] LINK_IDX = IDX_W'(LINK_REG);

  flow_kind_e        kind;
  logic [COND_W-1:0] cond;
  logic [IDX_W-1:0]  rd;
  logic [D22_W-1:0]  d22;
  logic [D30_W-1:0]  d30;
  logic              br_taken;

  // Named internal events for the checks below.
  logic ev_call, ev_jmpl, ev_branch, ev_br_skip;

  npc_decode u_dec (
    .instr (instr),
    .kind  (kind),
    .cond  (cond),
    .rd    (rd),
    .d22   (d22),
    .d30   (d30)
  );

  npc_cond u_cond (
    .cond  (cond),
    .f_n   (flag_n),
    .f_z   (flag_z),
    .f_c   (flag_c),
    .f_v   (flag_v),
    .taken (br_taken)
  );

  npc_target u_tgt (
    .kind     (kind),
    .br_taken (br_taken),
    .pc       (pc),
    .d22      (d22),
    .d30      (d30),
    .jmp_sum  (jmp_sum),
    .next_pc  (next_pc)
  );

  assign ev_call    = (kind == FK_CALL);
  assign ev_jmpl    = (kind == FK_JMPL);
  assign ev_branch  = (kind == FK_BRANCH);
  assign ev_br_skip = ev_branch && !br_taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc <= RESET_PC;
    else if (adv_en) pc <= next_pc;
  end

  assign link_we  = ev_call || (ev_jmpl && rd != '0);
  assign link_idx = ev_call ? LINK_IDX : rd;
  assign link_val = pc;

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_en |=> pc == $past(pc));

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en |=> pc == $past(next_pc));

  p_call_link_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_call |-> (link_we && link_idx == LINK_IDX && link_val == pc));

  p_always_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_branch && cond == CND_ALW) |-> next_pc == pc + br_offset(d22));

  p_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_br_skip |-> next_pc == pc + 32'd4);

  p_zero_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_jmpl && rd == '0) |-> !link_we);

  p_jmp_tgt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_jmpl |-> next_pc == jmp_sum);

  p_nolink_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_call && !ev_jmpl) |-> !link_we);

endmodule

// File: tb/tb_next_pc_unit.sv
module tb_next_pc_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        adv_en;
  logic [31:0] instr;
  logic        flag_n, flag_z, flag_c, flag_v;
  logic [31:0] jmp_sum;
  logic [31:0] pc, next_pc, link_val;
  logic        link_we;
  logic [4:0]  link_idx;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  next_pc_unit dut (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .instr(instr),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .jmp_sum(jmp_sum), .pc(pc), .next_pc(next_pc), .link_we(link_we),
    .link_idx(link_idx), .link_val(link_val)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (instr %h pc %h)", req, act, exp, instr, pc);
    end
  endtask

  function automatic logic [31:0] mk_call(input logic [29:0] d);
    return {2'b01, d};
  endfunction
  function automatic logic [31:0] mk_br(input logic [3:0] c, input logic [21:0] d);
    return {2'b00, 1'b0, c, 3'b010, d};
  endfunction
  function automatic logic [31:0] mk_jmpl(input logic [4:0] r);
    return {2'b10, r, 6'b111000, 5'd3, 1'b1, 13'h0004};
  endfunction

  // Expected branch decision, written from the R5 table.
  function automatic bit want_taken(input logic [3:0] c, input logic [3:0] f);
    // f = {n, z, c, v}
    if (c == 4'd1) return f[2] == 1'b1;
    if (c == 4'd6) return f[3] == 1'b1;
    if (c == 4'd5) return f[1] == 1'b1;
    if (c == 4'd7) return f[0] == 1'b1;
    if (c == 4'd8) return 1'b1;
    return 1'b0;
  endfunction

  task automatic set_pc(input logic [31:0] v);
    @(negedge clk);
    instr = mk_jmpl(5'd0); jmp_sum = v; adv_en = 1'b1;
    @(negedge clk);
    adv_en = 1'b0;
    chk("R2 pc load", pc, v);
  endtask

  task automatic branch_sweep(input logic [21:0] d);
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic [31:0] exp;
        int          sd;
        @(negedge clk);
        instr = mk_br(4'(c), d);
        {flag_n, flag_z, flag_c, flag_v} = 4'(f);
        #1;
        sd  = int'($signed(d));
        exp = want_taken(4'(c), 4'(f)) ? pc + 32'(sd * 4) : pc + 32'd4;
        if (want_taken(4'(c), 4'(f))) chk("R5 taken target", next_pc, exp);
        else                          chk("R6 not taken", next_pc, exp);
        chk("R8 branch no link", {31'd0, link_we}, 32'd0);
      end
    end
  endtask

  task automatic call_check(input logic [29:0] d);
    logic [31:0] exp;
    longint      sd;
    @(negedge clk);
    instr = mk_call(d);
    #1;
    sd  = longint'($signed(d));
    exp = pc + 32'(sd * 4);
    chk("R3 call target", next_pc, exp);
    chk("R4 call link we", {31'd0, link_we}, 32'd1);
    chk("R4 call link idx", {27'd0, link_idx}, 32'd15);
    chk("R4 call link val", link_val, pc);
  endtask

  initial begin
    rst_n = 1'b0; adv_en = 1'b0; instr = 32'h0;
    {flag_n, flag_z, flag_c, flag_v} = 4'h0; jmp_sum = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset pc", pc, 32'd2048);

    // R1: hold with a call presented.
    instr = mk_call(30'd100);
    repeat (3) @(negedge clk);
    chk("R1 hold", pc, 32'd2048);

    // R5/R6 at the reset PC and near the top of the address space.
    branch_sweep(22'd5);
    branch_sweep(22'h3FFFFB);
    set_pc(32'hFFFF_FFF0);
    branch_sweep(22'h000010);
    branch_sweep(22'h200000);
    set_pc(32'h0000_0100);
    branch_sweep(22'h1FFFFF);

    // R3/R4 calls at several PCs.
    call_check(30'd25);
    call_check(30'h3FFF_FFFF);
    call_check(30'h2000_0000);
    call_check(30'h1FFF_FFFF);
    call_check(30'd0);
    set_pc(32'hFFFF_FFFC);
    call_check(30'd1);
    call_check(30'h3FFF_FFF0);

    // R7 jump-and-link over every destination.
    for (int r = 0; r < 32; r++) begin
      @(negedge clk);
      instr = mk_jmpl(5'(r));
      jmp_sum = 32'(r) * 32'h0001_0000 + 32'h24;
      #1;
      chk("R7 jmpl target", next_pc, jmp_sum);
      chk("R7 jmpl link val", link_val, pc);
      chk("R7 jmpl link we", {31'd0, link_we}, (r != 0) ? 32'd1 : 32'd0);
      if (r != 0) chk("R7 jmpl link idx", {27'd0, link_idx}, 32'(r));
    end

    // R8: set-high and every other non-control form.
    for (int r = 0; r < 32; r++) begin
      @(negedge clk);
      instr = {2'b00, 5'(r), 3'b100, 22'h304F15};
      #1;
      chk("R8 sethi step", next_pc, pc + 32'd4);
      chk("R8 sethi no link", {31'd0, link_we}, 32'd0);
    end
    for (int s = 0; s < 8; s++) begin
      if (s == 2 || s == 4) continue;
      @(negedge clk);
      instr = {2'b00, 5'd8, 3'(s), 22'h00_0005};
      {flag_n, flag_z, flag_c, flag_v} = 4'hF;
      #1;
      chk("R8 op00 other step", next_pc, pc + 32'd4);
    end
    for (int s = 0; s < 64; s++) begin
      if (s == 56) continue;
      @(negedge clk);
      instr = {2'b10, 5'd15, 6'(s), 5'd1, 1'b1, 13'h0005};
      jmp_sum = 32'h1234_5678;
      #1;
      chk("R8 alu step", next_pc, pc + 32'd4);
      chk("R8 alu no link", {31'd0, link_we}, 32'd0);
      @(negedge clk);
      instr = {2'b11, 5'd15, 6'(s), 5'd1, 1'b1, 13'h0005};
      #1;
      chk("R8 mem step", next_pc, pc + 32'd4);
      chk("R8 mem no link", {31'd0, link_we}, 32'd0);
    end

    // R2: advance through a taken branch, a call and a sequential step.
    set_pc(32'h0000_1000);
    @(negedge clk);
    instr = mk_br(4'b1000, 22'h3FFFFE); adv_en = 1'b1;
    @(negedge clk);
    adv_en = 1'b0;
    chk("R2 advance branch", pc, 32'h0000_0FF8);
    @(negedge clk);
    instr = mk_call(30'd4); adv_en = 1'b1;
    @(negedge clk);
    adv_en = 1'b0;
    chk("R2 advance call", pc, 32'h0000_1008);
    @(negedge clk);
    instr = 32'h8080_0000; adv_en = 1'b1;
    @(negedge clk);
    adv_en = 1'b0;
    chk("R2 advance step", pc, 32'h0000_100C);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule